// File: doc/BRIEF.md
# LIN Frame Response Engine

This block runs the byte-level part of a LIN frame once break and sync have already gone out on the wire. A frame begins with a one-cycle `start` pulse. The engine copies the whole configuration into internal registers at that point, so later changes to the configuration inputs do not affect a frame already in progress.

In publish mode the engine does three things. It builds the protected identifier from the 6-bit `id_in`, sends it, and then sends the response bytes from its data buffer followed by the checksum. In subscribe mode it receives the protected identifier and checks its parity. It then stores the response bytes in the buffer and compares the received checksum against its own. In ignore mode it consumes the same byte sequence but raises no error and leaves the buffer untouched.

Bytes leave through a valid/ready transmit handshake toward a UART bit engine. They arrive as single-cycle receive strobes. Software fills and reads the buffer through a separate synchronous host port.

Top module: `lin_resp_engine`

## Requirements
- R1: After reset, `busy`, `tx_valid`, `frame_done`, `csum_err` and `par_err` are all 0.
- R2: In publish mode (`cfg_action` = 2'b00) the first transmitted byte is the protected identifier {P1, P0, id[5:0]}, where P0 = id0^id1^id2^id4 (bit 6) and P1 = ~(id1^id3^id4^id5) (bit 7).
- R3: With `cfg_par_off` = 1, the sent identifier carries 0 in bits 7:6, and a received identifier with wrong parity raises no `par_err`.
- R4: With `cfg_len_from_id` = 0 the response is `cfg_len`+1 bytes, from 1 up to 256. In publish mode the bytes are sent from buffer addresses 0 upward.
- R5: With `cfg_len_from_id` = 1 the response length comes from identifier bits 5:4: 00 and 01 give 2 bytes, 10 gives 4 and 11 gives 8.
- R6: With `cfg_classic` = 1 the checksum is the bitwise inverse of an 8-bit sum with end-around carry over the data bytes only.
- R7: With `cfg_classic` = 0 the checksum sum also includes the protected identifier byte as it appears on the wire.
- R8: With `cfg_csum_off` = 1 no checksum byte is sent or expected, and `csum_err` stays 0.
- R9: In subscribe mode (`cfg_action` = 2'b01) received data byte k is written to buffer address k. A checksum mismatch sets `csum_err`, which stays set until the next accepted `start`.
- R10: In subscribe mode, with parity enabled, a received identifier whose bits 7:6 differ from the parity of its bits 5:0 sets `par_err`, sticky until the next accepted `start`.
- R11: In ignore mode (`cfg_action` = 2'b10 or 2'b11) the buffer is not written and neither error flag is set.
- R12: `frame_done` is a one-cycle pulse, asserted in the cycle after the edge that accepts the frame's final byte, and `busy` is 0 in that cycle.
- R13: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` does not change.
- R14: A `start` pulse while `busy` is 1 is ignored, and the running frame completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame response (taken only when idle) |
| id_in | input | 6 | Frame identifier for publish mode |
| cfg_action | input | 2 | 00 publish, 01 subscribe, 10/11 ignore |
| cfg_len | input | LEN_W | Programmed response length minus one |
| cfg_len_from_id | input | 1 | Take the length from identifier bits 5:4 |
| cfg_classic | input | 1 | 1 classic checksum, 0 enhanced |
| cfg_csum_off | input | 1 | Disable checksum send and check |
| cfg_par_off | input | 1 | Disable parity generation and check |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | UART accepts the transmit byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| buf_we | input | 1 | Host buffer write enable |
| buf_addr | input | AW | Host buffer address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Host buffer read data, one cycle after address |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at frame end |
| csum_err | output | 1 | Sticky checksum mismatch |
| par_err | output | 1 | Sticky identifier parity mismatch |

## Verification
The timing of each result is fixed relative to the stimulus that causes it.

- Publish: the protected identifier is presented on `tx_data` one edge after `start` is taken. Every later byte is accepted at the edge where `tx_valid` and `tx_ready` are both high, so the monitor sets `tx_ready` at the falling edge and compares the byte at that same falling edge, just before the accepting edge.
- Frame end: `frame_done` and the final error flags appear one edge after the last byte is accepted or received. The bench checks them at the next falling edge, checks that the pulse has gone one cycle later, and compares the cycle count against the cycle of the last transmit handshake.
- Buffer reads: host data is compared one falling edge after the address is applied.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;

  typedef enum logic [1:0] {
    ACT_PUB = 2'b00,
    ACT_SUB = 2'b01,
    ACT_IGN = 2'b10
  } act_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PID_TX,
    ST_RD,
    ST_LD,
    ST_DTX,
    ST_CS_LD,
    ST_CS_TX,
    ST_PID_RX,
    ST_D_RX,
    ST_CS_RX
  } st_e;

endpackage

// File: rtl/lin_pid_gen.sv
module lin_pid_gen (
  input  logic [5:0] id,
  input  logic       par_off,
  output logic [7:0] pid
);
  logic p0, p1;
  assign p0  = id[0] ^ id[1] ^ id[2] ^ id[4];
  assign p1  = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
  assign pid = par_off ? {2'b00, id} : {p1, p0, id};
endmodule

// File: rtl/lin_csum_acc.sv
module lin_csum_acc #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] csum
);
  logic [DW-1:0] acc;
  logic [DW:0]   raw;

  assign raw  = {1'b0, acc} + {1'b0, din};
  assign csum = ~acc;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (add)   acc <= raw[DW-1:0] + {{(DW-1){1'b0}}, raw[DW]};
  end
endmodule

// File: rtl/lin_len_sel.sv
module lin_len_sel #(
  parameter int LEN_W = 8
) (
  input  logic             from_id,
  input  logic [LEN_W-1:0] len_cfg,
  input  logic [1:0]       id_hi,
  output logic [LEN_W-1:0] last_idx
);
  logic [LEN_W-1:0] id_last;

  always_comb begin
    case (id_hi)
      2'b10:   id_last = LEN_W'(3);
      2'b11:   id_last = LEN_W'(7);
      default: id_last = LEN_W'(1);
    endcase
  end

  assign last_idx = from_id ? id_last : len_cfg;
endmodule

// File: rtl/lin_resp_buf.sv
module lin_resp_buf #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_we)      mem[b_addr] <= b_wdata;
    else if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/lin_resp_engine.sv
module lin_resp_engine
  import lin_resp_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int LEN_W     = 8,
  localparam int AW       = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [5:0]       id_in,
  input  logic [1:0]       cfg_action,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_len_from_id,
  input  logic             cfg_classic,
  input  logic             cfg_csum_off,
  input  logic             cfg_par_off,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_wdata,
  output logic [7:0]       buf_rdata,
  output logic             busy,
  output logic             frame_done,
  output logic             csum_err,
  output logic             par_err
);

  st_e              state;
  act_e             act_q;
  logic [LEN_W-1:0] len_q, idx, last_idx;
  logic             from_id_q, classic_q, csum_off_q, par_off_q;
  logic [5:0]       id_q;
  logic [7:0]       pid_tx, pid_rx, csum, b_rdata, acc_din;
  logic             b_we, acc_add, acc_clr, is_last, take;

  lin_pid_gen u_pid_tx (.id(id_in),        .par_off(cfg_par_off), .pid(pid_tx));
  lin_pid_gen u_pid_rx (.id(rx_data[5:0]), .par_off(1'b0),        .pid(pid_rx));

  lin_len_sel #(.LEN_W(LEN_W)) u_len (
    .from_id(from_id_q), .len_cfg(len_q), .id_hi(id_q[5:4]), .last_idx(last_idx)
  );

  assign take    = (state == ST_IDLE) && start;
  assign acc_clr = take;
  assign acc_add = ((state == ST_PID_TX) && tx_ready && !classic_q)
                 || ((state == ST_PID_RX) && rx_valid && !classic_q)
                 || ((state == ST_DTX) && tx_ready)
                 || ((state == ST_D_RX) && rx_valid);
  assign acc_din = (state == ST_PID_TX || state == ST_DTX) ? tx_data : rx_data;

  lin_csum_acc #(.DW(8)) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .add(acc_add), .din(acc_din), .csum(csum)
  );

  assign b_we = (state == ST_D_RX) && rx_valid && (act_q == ACT_SUB);

  lin_resp_buf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
    .clk(clk),
    .a_we(buf_we), .a_addr(buf_addr), .a_wdata(buf_wdata), .a_rdata(buf_rdata),
    .b_we(b_we), .b_addr(idx[AW-1:0]), .b_wdata(rx_data), .b_rdata(b_rdata)
  );

  assign is_last = (idx == last_idx);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      act_q      <= ACT_PUB;
      len_q      <= '0;
      from_id_q  <= 1'b0;
      classic_q  <= 1'b0;
      csum_off_q <= 1'b0;
      par_off_q  <= 1'b0;
      id_q       <= '0;
      idx        <= '0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
      frame_done <= 1'b0;
      csum_err   <= 1'b0;
      par_err    <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          act_q      <= (cfg_action == 2'b00) ? ACT_PUB :
                        (cfg_action == 2'b01) ? ACT_SUB : ACT_IGN;
          len_q      <= cfg_len;
          from_id_q  <= cfg_len_from_id;
          classic_q  <= cfg_classic;
          csum_off_q <= cfg_csum_off;
          par_off_q  <= cfg_par_off;
          idx        <= '0;
          csum_err   <= 1'b0;
          par_err    <= 1'b0;
          if (cfg_action == 2'b00) begin
            id_q     <= id_in;
            tx_data  <= pid_tx;
            tx_valid <= 1'b1;
            state    <= ST_PID_TX;
          end else begin
            state    <= ST_PID_RX;
          end
        end
        ST_PID_TX: if (tx_ready) begin
          tx_valid <= 1'b0;
          state    <= ST_RD;
        end
        ST_RD: state <= ST_LD;
        ST_LD: begin
          tx_data  <= b_rdata;
          tx_valid <= 1'b1;
          state    <= ST_DTX;
        end
        ST_DTX: if (tx_ready) begin
          tx_valid <= 1'b0;
          idx      <= idx + 1'b1;
          if (!is_last)       state <= ST_RD;
          else if (csum_off_q) begin
            frame_done <= 1'b1;
            state      <= ST_IDLE;
          end else            state <= ST_CS_LD;
        end
        ST_CS_LD: begin
          tx_data  <= csum;
          tx_valid <= 1'b1;
          state    <= ST_CS_TX;
        end
        ST_CS_TX: if (tx_ready) begin
          tx_valid   <= 1'b0;
          frame_done <= 1'b1;
          state      <= ST_IDLE;
        end
        ST_PID_RX: if (rx_valid) begin
          id_q <= rx_data[5:0];
          if (act_q == ACT_SUB && !par_off_q && rx_data[7:6] != pid_rx[7:6])
            par_err <= 1'b1;
          state <= ST_D_RX;
        end
        ST_D_RX: if (rx_valid) begin
          idx <= idx + 1'b1;
          if (is_last) begin
            if (csum_off_q) begin
              frame_done <= 1'b1;
              state      <= ST_IDLE;
            end else state <= ST_CS_RX;
          end
        end
        ST_CS_RX: if (rx_valid) begin
          if (act_q == ACT_SUB && rx_data != csum) csum_err <= 1'b1;
          frame_done <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lin_resp_engine_chk.sv
module lin_resp_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       frame_done,
  input logic       csum_err,
  input logic       par_err,
  input logic [1:0] act,
  input logic       eng_we
);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !busy && !tx_valid && !frame_done && !csum_err && !par_err);

  a_r9_csum_err_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(csum_err) |-> frame_done);

  a_r10_par_err_in_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(par_err) |-> busy);

  a_r11_ignore_silent: assert property (@(posedge clk) disable iff (rst)
    (busy && act == 2'b10) |-> !eng_we && !tx_valid);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  a_r12_done_idle: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy);

  a_r13_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data));

  a_r14_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !frame_done) |=> busy || frame_done);

endmodule

bind lin_resp_engine lin_resp_engine_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .frame_done(frame_done),
  .csum_err(csum_err), .par_err(par_err), .act(act_q), .eng_we(b_we)
);

// File: tb/lin_resp_engine_tb_top.sv
module lin_resp_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [5:0] id_in = '0;
  logic [1:0] cfg_action = '0;
  logic [7:0] cfg_len = '0;
  logic cfg_len_from_id = 0, cfg_classic = 0, cfg_csum_off = 0, cfg_par_off = 0;
  logic tx_valid, tx_ready = 1'b1;
  logic [7:0] tx_data;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic buf_we = 1'b0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0, buf_rdata;
  logic busy, frame_done, csum_err, par_err;

  int checks = 0, errors = 0, cyc = 0, last_pop = 0;
  bit stall_en = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lin_resp_engine dut_i (
    .clk(clk), .rst(rst), .start(start), .id_in(id_in), .cfg_action(cfg_action),
    .cfg_len(cfg_len), .cfg_len_from_id(cfg_len_from_id), .cfg_classic(cfg_classic),
    .cfg_csum_off(cfg_csum_off), .cfg_par_off(cfg_par_off), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .busy(busy), .frame_done(frame_done), .csum_err(csum_err), .par_err(par_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_pid(input logic [5:0] id, input bit poff);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return poff ? {2'b00, id} : {p1, p0, id};
  endfunction

  function automatic int m_len(input logic [5:0] id, input bit from_id, input logic [7:0] l);
    if (!from_id) return int'(l) + 1;
    case (id[5:4]) 2'b10: return 4; 2'b11: return 8; default: return 2; endcase
  endfunction

  function automatic int m_add(input int s, input logic [7:0] b);
    int t;
    t = s + int'(b);
    if (t > 255) t = t - 255;
    return t;
  endfunction

  function automatic logic [7:0] m_data(input int seed, input int i);
    return 8'((seed * 29 + i * 71 + 5) ^ (i >> 3));
  endfunction

  // scoreboard monitor: drive ready, then compare the byte accepted at the next edge
  always @(negedge clk) begin
    tx_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
    if (!rst && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) check(0, "R2 unexpected tx byte", tx_data, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(tx_data == e, t, tx_data, e);
        last_pop = cyc;
      end
    end
  end

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_addr = AW'(a); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [7:0] d);
    @(negedge clk);
    buf_addr = AW'(a);
    @(negedge clk);
    d = buf_rdata;
  endtask

  task automatic set_cfg(input logic [1:0] act, input bit fid, input logic [7:0] l,
                         input bit cl, input bit co, input bit po);
    cfg_action = act; cfg_len_from_id = fid; cfg_len = l;
    cfg_classic = cl; cfg_csum_off = co; cfg_par_off = po;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!frame_done && n < 5000) begin @(negedge clk); n++; end
    check(frame_done == 1'b1, tag, frame_done, 1);
  endtask

  task automatic run_pub(input logic [5:0] id, input bit fid, input logic [7:0] l,
                         input bit cl, input bit co, input bit po,
                         input bit stall, input bit poke, input string tag);
    int n, s;
    logic [7:0] pid;
    n = m_len(id, fid, l);
    pid = m_pid(id, po);
    for (int i = 0; i < n; i++) host_write(i, m_data(id, i));
    s = cl ? 0 : int'(pid);
    exp_q.push_back(pid); tag_q.push_back({tag, " R2 pid"});
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(m_data(id, i)); tag_q.push_back({tag, " R4 data"});
      s = m_add(s, m_data(id, i));
    end
    if (!co) begin exp_q.push_back(~8'(s)); tag_q.push_back({tag, " R6 R7 checksum"}); end
    stall_en = stall;
    @(negedge clk);
    id_in = id; set_cfg(2'b00, fid, l, cl, co, po); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin   // R14: second start while busy must be ignored
      repeat (20) @(negedge clk);
      id_in = ~id; set_cfg(2'b01, 1'b0, 8'd0, 1'b1, 1'b1, 1'b1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done({tag, " R12 done"});
    check(cyc == last_pop + 1, {tag, " R12 done timing"}, cyc, last_pop + 1);
    check(exp_q.size() == 0 && busy == 1'b0, {tag, " R14 all bytes sent"}, exp_q.size(), 0);
    check(!csum_err && !par_err, {tag, " R8 no errors"}, {csum_err, par_err}, 0);
    @(negedge clk);
    check(frame_done == 1'b0, {tag, " R12 pulse width"}, frame_done, 0);
    stall_en = 0;
  endtask

  task automatic run_sub(input logic [1:0] act, input logic [7:0] pidraw, input bit fid,
                         input logic [7:0] l, input bit cl, input bit co, input bit po,
                         input bit bad_cs, input bit exp_pe, input bit exp_ce,
                         input string tag);
    int n, s;
    logic [7:0] d;
    n = m_len(pidraw[5:0], fid, l);
    s = cl ? 0 : int'(pidraw);
    @(negedge clk);
    set_cfg(act, fid, l, cl, co, po); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rx_valid = 1'b1; rx_data = pidraw;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_data = m_data(int'(pidraw) + 3, i);
      s = m_add(s, rx_data);
    end
    if (!co) begin
      @(negedge clk);
      rx_data = ~8'(s) ^ {7'd0, bad_cs};
    end
    @(negedge clk);
    rx_valid = 1'b0;
    check(frame_done == 1'b1 && busy == 1'b0, {tag, " R12 done"}, frame_done, 1);
    check(par_err == exp_pe, {tag, " R10 par_err"}, par_err, exp_pe);
    check(csum_err == exp_ce, {tag, " R9 csum_err"}, csum_err, exp_ce);
    if (act == 2'b01)
      for (int i = 0; i < n && i < 8; i++) begin
        host_read(i, d);
        check(d == m_data(int'(pidraw) + 3, i), {tag, " R9 stored byte"}, d, m_data(int'(pidraw) + 3, i));
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !tx_valid && !frame_done && !csum_err && !par_err, "R1 reset state",
          {busy, tx_valid, frame_done, csum_err, par_err}, 0);

    run_pub(6'h3C, 0, 8'd2, 1, 0, 0, 0, 0, "pub classic len3");
    run_pub(6'h15, 1, 8'd0, 0, 0, 0, 0, 0, "pub enhanced R5 id01");
    run_pub(6'h2A, 1, 8'd0, 0, 0, 1, 0, 0, "pub R3 paroff R5 id10");
    run_pub(6'h3F, 1, 8'd0, 0, 1, 0, 0, 0, "pub R8 csumoff R5 id11");
    run_pub(6'h07, 1, 8'd0, 1, 0, 0, 1, 0, "pub R5 id00 R13 stall");
    run_pub(6'h21, 0, 8'd255, 0, 0, 0, 1, 1, "pub R4 len256 R13 R14");
    run_pub(6'h11, 0, 8'd0, 0, 0, 0, 0, 0, "pub R4 len1");

    run_sub(2'b01, m_pid(6'h10, 0), 1, 8'd0, 1, 0, 0, 0, 0, 0, "sub classic ok");
    run_sub(2'b01, m_pid(6'h25, 0), 0, 8'd4, 0, 0, 0, 1, 0, 1, "sub R7 bad csum");
    repeat (5) @(negedge clk);
    check(csum_err == 1'b1, "R9 csum_err sticky", csum_err, 1);
    run_sub(2'b01, m_pid(6'h25, 0) ^ 8'h40, 0, 8'd2, 0, 0, 0, 0, 1, 0, "sub R10 bad parity");
    run_sub(2'b01, m_pid(6'h25, 0) ^ 8'h80, 0, 8'd2, 0, 0, 1, 0, 0, 0, "sub R3 parity off");
    run_sub(2'b01, m_pid(6'h33, 0), 1, 8'd0, 0, 1, 0, 0, 0, 0, "sub R8 csum off");

    for (int i = 0; i < 4; i++) host_write(i, 8'hC0 + 8'(i));
    run_sub(2'b10, m_pid(6'h01, 0) ^ 8'hC0, 0, 8'd3, 0, 0, 0, 1, 0, 0, "ign R11 flags");
    for (int i = 0; i < 4; i++) begin
      host_read(i, d);
      check(d == 8'hC0 + 8'(i), "R11 buffer untouched", d, 8'hC0 + 8'(i));
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule